// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Sequencer

This block sits between the serial bus controller of a non-volatile byte memory and its storage array. During a write transfer the bus controller hands it one byte at a time together with that byte's position inside a 32-byte page and the page number. The block keeps these bytes in a page register and marks each written position with a per-byte flag.

When the bus controller reports the STOP that ends the transfer, and at least one byte was taken, the block presents the whole page to the array in one cycle. The commit carries the page number, all 32 data bytes and a 32-bit mask that names the bytes that were actually written. The block then holds a busy output for a fixed programmable time. The time is counted as a number of ticks of a divided system clock. The bus controller uses busy to withhold acknowledges. While busy is high, every write and STOP strobe into the block is ignored.

A write-protect input blocks byte capture, so that a protected transfer commits nothing. The reset input is asynchronous and active low, and the block releases it synchronously inside.

Top module: `pgwr_sequencer`

## Requirements
- R1: After reset, busy and cm_stb are low, cm_mask is zero, every byte flag is clear and every page byte holds 0x00.
- R2: A write strobe taken while idle and unprotected stores wr_data at slot wr_ofs and sets that slot's flag. It also latches wr_page, so the page of the last accepted write is the page committed.
- R3: A STOP strobe while idle with at least one flag set makes cm_stb high for exactly one cycle, starting at the next clock edge. At that same edge busy rises. cm_page is the latched page. cm_mask bit k is the flag of slot k. cm_data bits [8k+7:8k] hold slot k.
- R4: A STOP strobe while no flag is set, such as after a transfer that carried only a word address, causes no commit, and busy stays low.
- R5: Busy stays high for exactly TICK_DIV × CYCLE_TICKS clock cycles and falls at the edge where the tick count expires.
- R6: While busy is high, write strobes and STOP strobes have no effect on the page bytes, the flags or the sequencer.
- R7: All flags clear at the commit. Page bytes are not cleared, so a later commit masks out bytes that were not rewritten, and those bytes still hold their earlier values in cm_data.
- R8: More than 32 writes in one transfer reuse slots as the offset wraps. A later write to a slot replaces the earlier byte, and the slot stays flagged once.
- R9: While wp_on is high, write strobes store nothing and set no flag. A STOP strobe after only protected writes starts no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe carrying a received data byte |
| wr_ofs | input | OFS_W (5) | Slot of the byte inside the page |
| wr_data | input | DATA_W (8) | Data byte |
| wr_page | input | PAGE_W (6) | Page number of the transfer |
| wp_on | input | 1 | Write protection, high blocks capture |
| stop_stb | input | 1 | One-cycle strobe marking the bus STOP |
| busy | output | 1 | Timed write cycle in progress |
| cm_stb | output | 1 | One-cycle commit strobe to the array |
| cm_page | output | PAGE_W (6) | Page number of the commit |
| cm_mask | output | SLOTS (32) | Per-byte write enables of the commit |
| cm_data | output | SLOTS*DATA_W (256) | Page bytes, slot k at bits [8k+7:8k] |

## Verification
The bench targets the boundaries of the busy window. It sends writes and a second STOP inside the window, and a STOP right after busy falls. If the window leaked, a second commit would appear or a byte would change. The bench measures the exact busy length, so a tick or cycle counter that is off by one shows up as a wrong count. A dummy STOP with no data, and a STOP after only protected writes, must produce no commit. A design that ignored the flags would commit or assert busy in those cases. A 40-byte transfer and a transfer that follows a commit check the slot wrap and the clearing of flags while data is kept. A design with wrong last-writer ordering, or with stale flags, would show a wrong mask or wrong data.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pgwr_page_store.sv
module pgwr_page_store #(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 8,
  localparam int OFS_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [OFS_W-1:0]        cap_ofs,
  input  logic [DATA_W-1:0]       cap_data,
  input  logic                    clr_flags,
  output logic [SLOTS-1:0]        flags,
  output logic [SLOTS*DATA_W-1:0] img
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] byte_q, byte_d;
    logic              flag_q, flag_d;

    assign hit = cap_en && (cap_ofs == OFS_W'(s));

    always_comb begin
      byte_d = byte_q;
      flag_d = flag_q;
      if (hit) begin
        byte_d = cap_data;
        flag_d = 1'b1;
      end else if (clr_flags) begin
        flag_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        flag_q <= 1'b0;
      end else begin
        if (hit) byte_q <= byte_d;
        if (hit || clr_flags) flag_q <= flag_d;
      end
    end

    assign img[s*DATA_W +: DATA_W] = byte_q;
    assign flags[s]                = flag_q;
  end

  // capture and flag clearing are made exclusive by the owner
  AST_CAP_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_en && clr_flags)); // R6

endmodule

// File: rtl/pgwr_tick_div.sv
module pgwr_tick_div #(
  parameter int TICK_DIV = 200,
  localparam int CW      = $clog2(TICK_DIV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(TICK_DIV - 1));
  assign tick = run && wrap;

  always_comb begin
    if (!run || wrap) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pgwr_cycle_ctl.sv
module pgwr_cycle_ctl
  import pgwr_pkg::*;
#(
  parameter int TICK_DIV    = 200,
  parameter int CYCLE_TICKS = 10000,
  localparam int TW         = $clog2(CYCLE_TICKS + 1),
  localparam int unsigned CYCLE_CLKS = TICK_DIV * CYCLE_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_stb,
  input  logic any_flag,
  input  logic tick,
  output logic launch,
  output logic busy,
  output logic cm_stb
);

  seq_state_e    st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          stb_q;

  assign launch = (st_q == SQ_IDLE) && stop_stb && any_flag;
  assign busy   = (st_q == SQ_RUN);
  assign cm_stb = stb_q;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (launch) begin
          st_d   = SQ_RUN;
          tcnt_d = '0;
        end
      end
      SQ_RUN: begin
        if (tick) begin
          if (tcnt_q == TW'(CYCLE_TICKS - 1)) st_d = SQ_IDLE;
          else                                tcnt_d = tcnt_q + TW'(1);
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      tcnt_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      stb_q  <= launch;
    end
  end

  // window checker: clocks spent busy since the rising edge
  logic [31:0] run_clks_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_clks_q <= '0;
    else if (busy) run_clks_q <= run_clks_q + 32'd1;
    else           run_clks_q <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_clks_q < CYCLE_CLKS)); // R5
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_clks_q == CYCLE_CLKS)); // R5
  AST_RISE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_stb) && cm_stb)); // R3

endmodule

// File: rtl/pgwr_sequencer.sv
module pgwr_sequencer #(
  parameter int SLOTS       = 32,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 6,
  parameter int TICK_DIV    = 200,
  parameter int CYCLE_TICKS = 10000,
  localparam int OFS_W      = $clog2(SLOTS),
  localparam int IMG_W      = SLOTS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wp_on,
  input  logic              stop_stb,
  output logic              busy,
  output logic              cm_stb,
  output logic [PAGE_W-1:0] cm_page,
  output logic [SLOTS-1:0]  cm_mask,
  output logic [IMG_W-1:0]  cm_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       lrst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign lrst_n = rst_sync_q[1];

  logic             take_wr;
  logic             launch;
  logic             tick;
  logic [SLOTS-1:0] flags;
  logic [IMG_W-1:0] img;

  // STOP wins over a write in the same cycle
  assign take_wr = wr_stb && !busy && !wp_on && !stop_stb;

  pgwr_page_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (lrst_n),
    .cap_en    (take_wr),
    .cap_ofs   (wr_ofs),
    .cap_data  (wr_data),
    .clr_flags (launch),
    .flags     (flags),
    .img       (img)
  );

  pgwr_tick_div #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (lrst_n),
    .run   (busy),
    .tick  (tick)
  );

  pgwr_cycle_ctl #(.TICK_DIV(TICK_DIV), .CYCLE_TICKS(CYCLE_TICKS)) u_ctl (
    .clk      (clk),
    .rst_n    (lrst_n),
    .stop_stb (stop_stb),
    .any_flag (|flags),
    .tick     (tick),
    .launch   (launch),
    .busy     (busy),
    .cm_stb   (cm_stb)
  );

  logic [PAGE_W-1:0] page_q, page_d;
  logic [SLOTS-1:0]  mask_q, mask_d;
  logic [PAGE_W-1:0] cpage_q, cpage_d;

  always_comb begin
    page_d  = take_wr ? wr_page : page_q;
    mask_d  = launch ? flags : mask_q;
    cpage_d = launch ? page_q : cpage_q;
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n) begin
      page_q  <= '0;
      mask_q  <= '0;
      cpage_q <= '0;
    end else begin
      if (take_wr) page_q <= page_d;
      if (launch) begin
        mask_q  <= mask_d;
        cpage_q <= cpage_d;
      end
    end
  end

  assign cm_page = cpage_q;
  assign cm_mask = mask_q;
  assign cm_data = img;

  AST_FREEZE_BUSY: assert property (@(posedge clk) disable iff (!lrst_n)
    busy |=> ($stable(flags) && $stable(img))); // R6
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!lrst_n)
    (wp_on && !launch) |=> ($stable(flags) && $stable(img))); // R9
  AST_COMMIT_SHAPE: assert property (@(posedge clk) disable iff (!lrst_n)
    cm_stb |-> (busy && (cm_mask != '0) && (flags == '0))); // R7
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!lrst_n)
    (stop_stb && !busy && (flags == '0)) |=> !busy); // R4

endmodule

// File: tb/test_pgwr_sequencer.sv
`timescale 1ns/1ps
module test_pgwr_sequencer;
  localparam int SLOTS = 32;
  localparam int DW    = 8;
  localparam int PW    = 6;
  localparam int OW    = 5;
  localparam int TD    = 3;
  localparam int CT    = 5;
  localparam int BUSYC = TD * CT;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_stb = 1'b0;
  logic [OW-1:0]     wr_ofs = '0;
  logic [DW-1:0]     wr_data = '0;
  logic [PW-1:0]     wr_page = '0;
  logic              wp_on = 1'b0;
  logic              stop_stb = 1'b0;
  logic              busy, cm_stb;
  logic [PW-1:0]     cm_page;
  logic [SLOTS-1:0]  cm_mask;
  logic [SLOTS*DW-1:0] cm_data;

  always #2.5 clk = ~clk;

  pgwr_sequencer #(.SLOTS(SLOTS), .DATA_W(DW), .PAGE_W(PW),
                   .TICK_DIV(TD), .CYCLE_TICKS(CT)) i_pgwr_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .wr_page(wr_page), .wp_on(wp_on),
    .stop_stb(stop_stb), .busy(busy), .cm_stb(cm_stb),
    .cm_page(cm_page), .cm_mask(cm_mask), .cm_data(cm_data));

  typedef struct packed {
    logic [PW-1:0]       page;
    logic [SLOTS-1:0]    mask;
    logic [SLOTS*DW-1:0] data;
  } item_t;

  item_t          expq[$];
  logic [DW-1:0]  m_byte [SLOTS];
  logic [SLOTS-1:0] m_vld = '0;
  logic [PW-1:0]  m_page = '0;
  int    checks = 0, errors = 0, bcnt = 0;
  bit    done = 0;
  string cur_req = "R3";

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic item_t snap();
    item_t it;
    it.page = m_page;
    it.mask = m_vld;
    for (int k = 0; k < SLOTS; k++) it.data[k*DW +: DW] = m_byte[k];
    return it;
  endfunction

  // drivers: called just after a falling edge, return after the next one
  task automatic wr(input int ofs, input int dat, input int pg, input bit taken);
    wr_stb = 1'b1; wr_ofs = OW'(ofs); wr_data = DW'(dat); wr_page = PW'(pg);
    if (taken) begin
      m_byte[ofs] = DW'(dat);
      m_vld[ofs]  = 1'b1;
      m_page      = PW'(pg);
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic stp(input bit commit);
    stop_stb = 1'b1;
    if (commit) begin
      expq.push_back(snap());
      m_vld = '0;
    end
    @(negedge clk);
    stop_stb = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // monitor: commits against the scoreboard, busy window length
  always @(negedge clk) begin
    if (rst_n) begin
      if (cm_stb) begin
        if (expq.size() == 0) begin
          chk(1'b0, cur_req, $sformatf("unexpected commit actual=1 expected=0 mask=%h", cm_mask));
        end else begin
          item_t e;
          e = expq.pop_front();
          chk(cm_page == e.page, cur_req, $sformatf("page actual=%0d expected=%0d", cm_page, e.page));
          chk(cm_mask == e.mask, cur_req, $sformatf("mask actual=%h expected=%h", cm_mask, e.mask));
          chk(cm_data == e.data, cur_req, $sformatf("data actual=%h expected=%h", cm_data, e.data));
        end
      end
      if (busy) bcnt++;
      else if (bcnt != 0) begin
        chk(bcnt == BUSYC, "R5", $sformatf("busy length actual=%0d expected=%0d", bcnt, BUSYC));
        bcnt = 0;
      end
    end
  end

  initial begin
    for (int k = 0; k < SLOTS; k++) m_byte[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", $sformatf("busy actual=%b expected=0", busy));
    chk(cm_stb == 1'b0, "R1", $sformatf("cm_stb actual=%b expected=0", cm_stb));
    chk(cm_mask == '0, "R1", $sformatf("cm_mask actual=%h expected=0", cm_mask));

    // R1 R2 R3: single byte, other slots must read as zero
    cur_req = "R1";
    wr(7, 8'hA5, 3, 1);
    stp(1);
    chk(busy == 1'b1, "R3", $sformatf("busy after STOP actual=%b expected=1", busy));
    wait_idle();

    // R4: dummy STOP without data
    stp(0);
    chk(busy == 1'b0, "R4", $sformatf("busy after empty STOP actual=%b expected=0", busy));
    @(negedge clk);

    // R2: page of last accepted write, both page ends of the slot range
    cur_req = "R2";
    wr(0, 8'h11, 5, 1);
    wr(31, 8'h22, 9, 1);
    wr(16, 8'h33, 9, 1);
    stp(1);
    wait_idle();

    // R6: strobes inside the busy window
    cur_req = "R6";
    wr(2, 8'h44, 1, 1);
    stp(1);
    wr(3, 8'hEE, 1, 0);
    wr(2, 8'hFF, 1, 0);
    stp(0);
    wait_idle();
    stp(0);
    chk(busy == 1'b0, "R6", $sformatf("busy after STOP at window end actual=%b expected=0", busy));

    // R7: new mask only, earlier bytes kept in data
    cur_req = "R7";
    wr(4, 8'h55, 1, 1);
    stp(1);
    wait_idle();

    // R8: 40 bytes, offset wraps
    cur_req = "R8";
    for (int i = 0; i < 40; i++) wr(i % 32, i + 8'h60, 12, 1);
    stp(1);
    wait_idle();

    // R9: write protection
    cur_req = "R9";
    wp_on = 1'b1;
    wr(5, 8'h66, 2, 0);
    stp(0);
    chk(busy == 1'b0, "R9", $sformatf("busy after protected transfer actual=%b expected=0", busy));
    wp_on = 1'b0;
    wr(6, 8'h77, 2, 1);
    wp_on = 1'b1;
    wr(8, 8'h88, 2, 0);
    wp_on = 1'b0;
    stp(1);
    wait_idle();

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R3", $sformatf("pending commits actual=%0d expected=0", expq.size()));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule